// File: doc/BRIEF.md
# Reset Supervisor with Pushbutton Debounce

This block runs an active-low system reset line that is also the input of an external pushbutton. It pulls the line low while a digital power-fail level is active. When power recovers it keeps the line low for a fixed hold. When oscillator-disable is set, that hold gets an extra startup stretch. A one-cycle watchdog request starts the same fixed hold. Time is counted in ticks of a 4096 Hz strobe, so 1024 ticks make 250 ms.

When no reset sequence is running, the block watches a synchronized copy of the line. A falling edge there means the button was pressed. The block then drives the line low for one hold period to debounce the switch and lets go. If the line stays low, it waits for the button to be released. After the release it drives one more hold period. An access-inhibit output stays high through every phase of every sequence, so the register interface is locked out. Power failure overrides any other phase at any time.

Top module: `rstsup_top`

## Requirements
- R1: While `pwr_fail_i` is 1, `rst_drive_o` and `access_inhibit_o` are 1 from the next clock edge on.
- R2: After `pwr_fail_i` returns to 0, `rst_drive_o` stays 1 for HOLD_TICKS ticks (one extra cycle of latency) and then drops to 0.
- R3: If `osc_dis_i` is 1 when power recovers, the post-power hold lasts HOLD_TICKS + OSC_TICKS ticks.
- R4: While `rst_n` is low, both outputs are 1. After `rst_n` rises, the block runs the post-power hold.
- R5: When idle, a high-to-low transition of the sensed line (after a two-flop synchronizer) starts a debounce phase. In that phase `rst_drive_o` is 1 for HOLD_TICKS ticks.
- R6: After the debounce, the drive is released and `access_inhibit_o` stays 1 for as long as the sensed line is low.
- R7: Once the sensed line reads high after a settle time of SYNC_STAGES+1 cycles, the block drives a second HOLD_TICKS hold. The inhibit stays 1 without a break from the debounce to the end of this hold.
- R8: The line rising or falling because of the block's own drive never starts a new sequence. After a sequence ends, both outputs stay 0 until a new stimulus arrives.
- R9: A 1 on `wdog_req_i` while idle starts a HOLD_TICKS hold from the next edge. Outside the idle state the request is ignored.
- R10: Power failure overrides any button or watchdog phase: the drive is 1 from the next edge.
- R11: Hold timers advance only in cycles where `tick_i` is 1.
- R12: `access_inhibit_o` is 0 exactly when no sequence is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe at 4096 Hz |
| pwr_fail_i | input | 1 | Digital power-fail level, 1 = supply out of tolerance |
| osc_dis_i | input | 1 | Adds the oscillator startup stretch to the post-power hold |
| wdog_req_i | input | 1 | Watchdog expiry request, one cycle |
| rst_line_i | input | 1 | Sensed level of the shared reset line |
| rst_drive_o | output | 1 | 1 = pull the reset line low |
| access_inhibit_o | output | 1 | 1 = block register reads and writes |

## Verification
Button presses are tried in two directed forms and with random lengths. A press shorter than the debounce shows that release is detected by level, not only by an edge after the debounce. A long press shows the wait phase with the drive released. The random lengths check that the inhibit window grows with the press only once the press outlasts the debounce. Power fail with and without oscillator-disable tells the plain hold from the extended one. Stopping the tick strobe during a hold, sending a watchdog request during a button wait, and raising power fail in mid-sequence separately test tick gating, the idle-only watchdog and the override priority.

// File: rtl/rstsup_pkg.sv
// Shared types for the reset supervisor.
package rstsup_pkg;
    // Sequencer phases. Drive and inhibit are decoded from these.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PFAIL = 3'd1,
        ST_PHOLD = 3'd2,
        ST_BDEB  = 3'd3,
        ST_BWAIT = 3'd4,
        ST_BHOLD = 3'd5,
        ST_WHOLD = 3'd6
    } rst_state_e;
endpackage

// File: rtl/rstsup_line_sync.sv
// Synchronizes the sensed reset line and flags falling edges.
// Assumes the line idles high. The chain resets to 1 so that no false edge appears.
module rstsup_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic fall_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= {chain_q[STAGES-2:0], line_i};
    end

    // Keep last synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign level_o = chain_q[STAGES-1];
    assign fall_o  = prev_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/rstsup_hold_timer.sv
// Loadable down counter in tick units. zero_o is 1 when the count is zero.
// Assumes tick_i is a single-cycle strobe. A load overrides the tick.
module rstsup_hold_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o,
    output logic [W-1:0] count_o
);
    logic [W-1:0] cnt_q;

    // Load on request, otherwise count down one per tick until zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (load_i)                  cnt_q <= load_val_i;
        else if (tick_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign zero_o  = (cnt_q == '0);
    assign count_o = cnt_q;
endmodule

// File: rtl/rstsup_seq.sv
// Reset phase sequencer: power fail, post-power hold, button debounce/wait/hold,
// and watchdog hold. Power fail wins over every other phase. Line edges are
// accepted only after the line has settled for SETTLE cycles with no drive, so
// the block's own drive never triggers a sequence.
module rstsup_seq
    import rstsup_pkg::*;
#(
    parameter int W          = 11,
    parameter int HOLD_TICKS = 1024,
    parameter int OSC_TICKS  = 512,
    parameter int SETTLE     = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwr_fail_i,
    input  logic         osc_dis_i,
    input  logic         wdog_req_i,
    input  logic         line_level_i,
    input  logic         line_fall_i,
    input  logic         tmr_zero_i,
    output logic         tmr_load_o,
    output logic [W-1:0] tmr_val_o,
    output logic         drive_o,
    output logic         inhibit_o,
    output rst_state_e   state_o
);
    localparam int SW = $clog2(SETTLE + 1);
    localparam logic [W-1:0]  HOLD_V   = W'(HOLD_TICKS);
    localparam logic [W-1:0]  EXT_V    = W'(HOLD_TICKS + OSC_TICKS);
    localparam logic [SW-1:0] SETTLE_V = SW'(SETTLE);

    rst_state_e    state_q, state_d;
    logic [SW-1:0] settle_q;
    logic          ready;

    // Count settle cycles since the drive was last released.
    always_ff @(posedge clk) begin
        if (!rst_n)              settle_q <= SETTLE_V;
        else if (drive_o)        settle_q <= SETTLE_V;
        else if (settle_q != '0) settle_q <= settle_q - 1'b1;
    end

    assign ready = (settle_q == '0);

    // Next phase and timer load selection.
    always_comb begin
        state_d    = state_q;
        tmr_load_o = 1'b0;
        tmr_val_o  = HOLD_V;
        if (pwr_fail_i) begin
            state_d = ST_PFAIL;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (wdog_req_i) begin
                        state_d    = ST_WHOLD;
                        tmr_load_o = 1'b1;
                    end else if (line_fall_i && ready) begin
                        state_d    = ST_BDEB;
                        tmr_load_o = 1'b1;
                    end
                end
                ST_PFAIL: begin
                    state_d    = ST_PHOLD;
                    tmr_load_o = 1'b1;
                    tmr_val_o  = osc_dis_i ? EXT_V : HOLD_V;
                end
                ST_BDEB: begin
                    if (tmr_zero_i) state_d = ST_BWAIT;
                end
                ST_BWAIT: begin
                    if (ready && line_level_i) begin
                        state_d    = ST_BHOLD;
                        tmr_load_o = 1'b1;
                    end
                end
                ST_PHOLD, ST_BHOLD, ST_WHOLD: begin
                    if (tmr_zero_i) state_d = ST_IDLE;
                end
                default: state_d = ST_PFAIL;
            endcase
        end
    end

    // Phase register. Reset enters the power-fail phase.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_PFAIL;
        else        state_q <= state_d;
    end

    assign drive_o   = (state_q == ST_PFAIL) || (state_q == ST_PHOLD) ||
                       (state_q == ST_BDEB)  || (state_q == ST_BHOLD) ||
                       (state_q == ST_WHOLD);
    assign inhibit_o = (state_q != ST_IDLE);
    assign state_o   = state_q;
endmodule

// File: rtl/rstsup_top.sv
// Reset supervisor top: line synchronizer, hold timer and phase sequencer.
// Assumes tick_i pulses at 4096 Hz (HOLD_TICKS = 1024 gives 250 ms) and that
// pwr_fail_i is already synchronous to clk.
module rstsup_top
    import rstsup_pkg::*;
#(
    parameter int HOLD_TICKS  = 1024,
    parameter int OSC_TICKS   = 512,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic pwr_fail_i,
    input  logic osc_dis_i,
    input  logic wdog_req_i,
    input  logic rst_line_i,
    output logic rst_drive_o,
    output logic access_inhibit_o
);
    localparam int CNT_W  = $clog2(HOLD_TICKS + OSC_TICKS + 1);
    localparam int SETTLE = SYNC_STAGES + 1;

    logic             line_level, line_fall;
    logic             tmr_zero, tmr_load;
    logic [CNT_W-1:0] tmr_val, tmr_cnt;
    rst_state_e       state;

    rstsup_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (rst_line_i),
        .level_o (line_level),
        .fall_o  (line_fall)
    );

    rstsup_hold_timer #(.W(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick_i),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero),
        .count_o    (tmr_cnt)
    );

    rstsup_seq #(
        .W          (CNT_W),
        .HOLD_TICKS (HOLD_TICKS),
        .OSC_TICKS  (OSC_TICKS),
        .SETTLE     (SETTLE)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_fail_i   (pwr_fail_i),
        .osc_dis_i    (osc_dis_i),
        .wdog_req_i   (wdog_req_i),
        .line_level_i (line_level),
        .line_fall_i  (line_fall),
        .tmr_zero_i   (tmr_zero),
        .tmr_load_o   (tmr_load),
        .tmr_val_o    (tmr_val),
        .drive_o      (rst_drive_o),
        .inhibit_o    (access_inhibit_o),
        .state_o      (state)
    );
endmodule

// File: rtl/rstsup_chk.sv
// Property checker for rstsup_top, attached with bind below.
// Assumes that the internal phase, timer count and timer load are visible in the bound scope.
module rstsup_chk
    import rstsup_pkg::*;
#(
    parameter int CW = 11
) (
    input logic          clk,
    input logic          rst_n,
    input logic          tick_i,
    input logic          pwr_fail_i,
    input logic          wdog_req_i,
    input logic          drive_o,
    input logic          inhibit_o,
    input rst_state_e    state_i,
    input logic [CW-1:0] tmr_cnt_i,
    input logic          tmr_load_i
);
    // R1
    pfail_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_fail_i |=> (drive_o && inhibit_o));

    // R2
    pf_release_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_fail_i) |=> drive_o);

    // R6
    wait_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_BWAIT) |-> (!drive_o && inhibit_o));

    // R11
    tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !tmr_load_i) |=> $stable(tmr_cnt_i));

    // R9
    wdog_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_IDLE && wdog_req_i && !pwr_fail_i) |=> (state_i == ST_WHOLD && drive_o));

    // R10
    pfail_override_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_fail_i && state_i != ST_IDLE) |=> (state_i == ST_PFAIL));
endmodule

bind rstsup_top rstsup_chk #(.CW(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_i),
    .pwr_fail_i (pwr_fail_i),
    .wdog_req_i (wdog_req_i),
    .drive_o    (rst_drive_o),
    .inhibit_o  (access_inhibit_o),
    .state_i    (state),
    .tmr_cnt_i  (tmr_cnt),
    .tmr_load_i (tmr_load)
);

// File: tb/rstsup_top_test.sv
// Self-checking bench for rstsup_top with short hold parameters.
module rstsup_top_test;
    localparam int HOLD = 20;
    localparam int OSC  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_en = 1'b1;
    logic pwr_fail = 1'b0;
    logic osc_dis = 1'b0;
    logic wdog = 1'b0;
    logic btn = 1'b0;
    logic drive, inhibit, line;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // Open-drain line: low when the block drives or the button is held.
    assign line = ~(drive | btn);

    rstsup_top #(.HOLD_TICKS(HOLD), .OSC_TICKS(OSC), .SYNC_STAGES(2)) uut (
        .clk              (clk),
        .rst_n            (rst_n),
        .tick_i           (tick_en),
        .pwr_fail_i       (pwr_fail),
        .osc_dis_i        (osc_dis),
        .wdog_req_i       (wdog),
        .rst_line_i       (line),
        .rst_drive_o      (drive),
        .access_inhibit_o (inhibit)
    );

    function automatic int hold_len(input logic ext);
        return HOLD + (ext ? OSC : 0);
    endfunction

    // Expected inhibit window in cycles for a press lasting len cycles.
    function automatic int press_window(input int len);
        int a = len + HOLD + 1;
        int b = 2 * HOLD + 6;
        return (a > b) ? a : b;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count cycles the drive stays high, starting now.
    task automatic drive_len(output int n);
        n = 0;
        while (drive && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // Count cycles the inhibit stays high, after waiting for it to rise.
    task automatic inhibit_len(output int n);
        int w = 0;
        n = 0;
        while (!inhibit && w < 10) begin
            @(negedge clk);
            w++;
        end
        while (inhibit && n < 5000) begin
            @(negedge clk);
            n++;
        end
        n = n + w;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int n;
        int stuck;
        void'($urandom(32'h5eed_1374));

        // R4: reset state
        cyc(3);
        check(drive && inhibit, "R4 reset outputs", {drive, inhibit}, 3);
        rst_n = 1'b1;
        drive_len(n);
        check(n >= HOLD && n <= HOLD + 3, "R4 post-reset hold", n, HOLD + 1);
        cyc(2);
        // R12
        check(!inhibit && !drive, "R12 idle outputs", {drive, inhibit}, 0);

        // R1 / R2: plain power fail
        pwr_fail = 1'b1;
        cyc(1);
        check(drive && inhibit, "R1 power fail asserts", {drive, inhibit}, 3);
        cyc(30);
        check(drive, "R1 held during fail", drive, 1);
        pwr_fail = 1'b0;
        drive_len(n);
        check(n >= hold_len(1'b0) && n <= hold_len(1'b0) + 2, "R2 recovery hold", n, hold_len(1'b0) + 1);
        cyc(2);

        // R3: extended hold with oscillator-disable
        osc_dis = 1'b1;
        pwr_fail = 1'b1;
        cyc(5);
        pwr_fail = 1'b0;
        drive_len(n);
        check(n >= hold_len(1'b1) && n <= hold_len(1'b1) + 2, "R3 extended hold", n, hold_len(1'b1) + 1);
        osc_dis = 1'b0;
        cyc(2);

        // R11: ticks stopped freeze the watchdog hold
        tick_en = 1'b0;
        wdog = 1'b1;
        cyc(1);
        wdog = 1'b0;
        stuck = 1;
        for (int i = 0; i < 3 * HOLD; i++) begin
            if (!drive) stuck = 0;
            cyc(1);
        end
        check(stuck == 1, "R11 hold frozen without tick", stuck, 1);
        tick_en = 1'b1;
        drive_len(n);
        check(n >= HOLD - 1 && n <= HOLD + 2, "R11 hold resumes on tick", n, HOLD + 1);
        cyc(3);

        // R9: watchdog request from idle
        wdog = 1'b1;
        cyc(1);
        wdog = 1'b0;
        check(drive && inhibit, "R9 watchdog starts hold", drive, 1);
        drive_len(n);
        check(n >= HOLD && n <= HOLD + 2, "R9 watchdog hold length", n, HOLD + 1);
        cyc(3);

        // R5 / R6 / R7: long press
        btn = 1'b1;
        cyc(4);
        check(drive && inhibit, "R5 debounce drive", drive, 1);
        drive_len(n);
        check(n >= HOLD - 1 && n <= HOLD + 2, "R5 debounce length", n, HOLD + 1);
        stuck = 1;
        for (int i = 0; i < 15; i++) begin
            if (drive || !inhibit) stuck = 0;
            if (i == 5) wdog = 1'b1;
            if (i == 6) wdog = 1'b0;
            cyc(1);
        end
        check(stuck == 1, "R6 wait phase released, R9 request ignored", stuck, 1);
        btn = 1'b0;
        cyc(5);
        check(drive, "R7 release hold starts", drive, 1);
        drive_len(n);
        check(n >= HOLD - 2 && n <= HOLD + 2, "R7 release hold length", n, HOLD + 1);
        cyc(1);
        check(!inhibit, "R7 idle after hold", inhibit, 0);
        // R8: no self-triggered sequence
        stuck = 0;
        for (int i = 0; i < 3 * HOLD; i++) begin
            if (drive || inhibit) stuck = 1;
            cyc(1);
        end
        check(stuck == 0, "R8 no restart from own drive", stuck, 0);

        // R7: short press released during debounce
        btn = 1'b1;
        cyc(3);
        btn = 1'b0;
        inhibit_len(n);
        check(n >= press_window(0) - 3 && n <= press_window(0) + 3, "R7 short press window", n, press_window(0));
        cyc(3);

        // R10: power fail during button wait
        btn = 1'b1;
        cyc(4);
        drive_len(n);
        cyc(3);
        pwr_fail = 1'b1;
        cyc(1);
        check(drive, "R10 power fail overrides wait", drive, 1);
        btn = 1'b0;
        cyc(4);
        pwr_fail = 1'b0;
        drive_len(n);
        check(n >= HOLD && n <= HOLD + 2, "R10 recovery after override", n, HOLD + 1);
        cyc(3);
        check(!inhibit, "R10 back to idle", inhibit, 0);

        // R5 / R7 random press lengths
        for (int k = 0; k < 10; k++) begin
            int len = 1 + int'($urandom_range(60));
            fork
                begin
                    btn = 1'b1;
                    cyc(len);
                    btn = 1'b0;
                end
            join_none
            inhibit_len(n);
            check(n >= press_window(len) - 3 && n <= press_window(len) + 3,
                  "R7 random press window", n, press_window(len));
            cyc(4 + int'($urandom_range(6)));
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule